// File: doc/BRIEF.md
# Serial Port Register and Flag Logic

This block holds the software-visible control and status state of an asynchronous serial port. A byte-wide register bus reaches a control register, a status register, a transmit data register and a read-only receive buffer. The block keeps five status flags (transmit buffer empty, receive buffer full, overrun, framing error and parity error) and drives three interrupt lines from them. The bit-level shifter and baud logic sit outside. The shifter gets a start strobe and the transmit byte. The receiver gets an enable level. The shifter reports back with single-cycle pulses.

A flag is cleared in two steps. Software first reads the status register while the flag is 1. It then writes the status register with a 0 in that flag's position. Each status write uses up the remembered reads. Turning the transmitter off pins the transmit-empty flag at 1. Turning the receiver off leaves every receive flag and the receive buffer as they were.

Top module: `sport_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00 and the status register reads 0x80. All interrupt lines, `tx_start_o` and `rx_en_o` are low.
- R2: Control register (address 0): bit 7 transmit interrupt enable, bit 6 receive interrupt enable, bit 5 transmit enable, bit 4 receive enable. These bits read back what was written, and bits 3:0 read 0. Status register (address 1): bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bits 2:0 read 0. Transmit data is at address 2 and the receive buffer at address 3.
- R3: `irq_tx_o` is high exactly when the transmit interrupt enable and the transmit-empty flag are both 1.
- R4: `irq_rx_o` is receive interrupt enable AND receive full. `irq_err_o` is receive interrupt enable AND (overrun OR framing OR parity). Clearing the enable drops both lines.
- R5: Writing 0 to a status bit clears that flag only if a status read returned it as 1 since the last status write. Writing 1 to a status bit has no effect.
- R6: Every status write discards all remembered reads, so a second write of 0 does not clear a flag.
- R7: With transmit enable at 1, once transmit data has been written and transmit empty is 0, `tx_start_o` pulses for one cycle. The pulse comes one cycle after both conditions hold, and `tx_data_o` carries the written byte. It fires once per data write.
- R8: A `tx_loaded_i` pulse sets the transmit-empty flag.
- R9: While transmit enable is 0, the transmit-empty flag stays at 1 and cannot be cleared.
- R10: `rx_en_o` follows receive enable. Clearing receive enable changes no receive flag and not the receive buffer.
- R11: A received byte (`rx_done_i` pulse) with receive enable 1 and receive full 0 stores `rx_data_i` in the receive buffer and sets receive full. While receive enable is 0, byte and error pulses are ignored.
- R12: A byte arriving while receive full is 1 sets the overrun flag and leaves the receive buffer unchanged.
- R13: An `rx_err_i` pulse sets the framing flag when `rx_fe_i` is 1 and the parity flag when `rx_pe_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cs_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| tx_start_o | output | 1 | One-cycle start strobe to the transmit shifter |
| tx_data_o | output | 8 | Byte to transmit |
| tx_loaded_i | input | 1 | Shifter has taken the transmit byte |
| rx_en_o | output | 1 | Receiver enable |
| rx_done_i | input | 1 | Byte received pulse |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error pulse |
| rx_fe_i | input | 1 | Qualifier: framing error |
| rx_pe_i | input | 1 | Qualifier: parity error |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Receive error interrupt |

## Verification
The assertions check the following on every cycle:
- a write of 1, or a write without a prior read of 1, never drops a flag;
- each status write discards the remembered reads;
- the start strobe never lasts two cycles;
- transmit empty is held high while the transmitter is off;
- receive full cannot rise while the receiver is off;
- an overrun never touches the receive buffer.

The bench scenarios cover what needs a history of bus traffic: the full read-then-write sequences, the exact cycle of the start strobe and the byte it carries, the cancelling of interrupts through either path, and the flags and buffer contents kept across a receiver shutdown.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int SP_DW       = 8;
  localparam int SP_AW       = 2;
  localparam int SP_NFLAG    = 5;
  localparam int SP_FLAG_LSB = 3;
  localparam int SP_NCTRL    = 4;
  localparam int SP_CTRL_LSB = 4;

  // flag index (status bit = SP_FLAG_LSB + index)
  localparam int FI_PER  = 0;
  localparam int FI_FER  = 1;
  localparam int FI_ORER = 2;
  localparam int FI_RDRF = 3;
  localparam int FI_TDRE = 4;

  // control index (control bit = SP_CTRL_LSB + index)
  localparam int CI_RE  = 0;
  localparam int CI_TE  = 1;
  localparam int CI_RIE = 2;
  localparam int CI_TIE = 3;

  typedef enum logic [SP_AW-1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_TDR  = 2'd2,
    RA_RDR  = 2'd3
  } sp_reg_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_stat;
    logic rd_stat;
    logic wr_tdr;
  } sp_strobe_t;
endpackage

// File: rtl/sport_bus_dec.sv
module sport_bus_dec
  import sport_pkg::*;
(
  input  logic                bus_cs_i,
  input  logic                bus_we_i,
  input  logic [SP_AW-1:0]    bus_addr_i,
  input  logic [SP_NCTRL-1:0] ctrl_i,
  input  logic [SP_NFLAG-1:0] flag_i,
  input  logic [SP_DW-1:0]    tdr_i,
  input  logic [SP_DW-1:0]    rdr_i,
  output sp_strobe_t          stb_o,
  output logic [SP_DW-1:0]    rdata_o
);
  sp_reg_e sel;
  assign sel = sp_reg_e'(bus_addr_i);

  always_comb begin
    stb_o   = '0;
    rdata_o = '0;
    if (bus_cs_i) begin
      case (sel)
        RA_CTRL: begin
          if (bus_we_i) stb_o.wr_ctrl = 1'b1;
          else          rdata_o[SP_CTRL_LSB +: SP_NCTRL] = ctrl_i;
        end
        RA_STAT: begin
          if (bus_we_i) stb_o.wr_stat = 1'b1;
          else begin
            stb_o.rd_stat = 1'b1;
            rdata_o[SP_FLAG_LSB +: SP_NFLAG] = flag_i;
          end
        end
        RA_TDR: begin
          if (bus_we_i) stb_o.wr_tdr = 1'b1;
          else          rdata_o = tdr_i;
        end
        RA_RDR: begin
          if (!bus_we_i) rdata_o = rdr_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sport_flag.sv
module sport_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wbit_i,
  input  logic set_i,
  input  logic force_i,
  output logic q_o
);
  logic q_q, q_n, armed_q, armed_n, upd;

  assign upd = rd_stat_i | wr_stat_i | set_i | force_i;

  always_comb begin
    armed_n = armed_q;
    if (rd_stat_i && q_q) armed_n = 1'b1;
    if (wr_stat_i)        armed_n = 1'b0;
    q_n = q_q;
    if (wr_stat_i && !wbit_i && armed_q) q_n = 1'b0;
    if (set_i || force_i)                q_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= RST_VAL;
      armed_q <= 1'b0;
    end else if (upd) begin
      q_q     <= q_n;
      armed_q <= armed_n;
    end
  end

  assign q_o = q_q;

  // R5: a written 1 never clears
  a_r5_one_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && wr_stat_i && wbit_i) |=> q_o);
  // R5: without a prior read of 1 the write does nothing
  a_r5_unread_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !armed_q && wr_stat_i) |=> q_o);
  // R6: status write consumes the remembered read
  a_r6_write_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i |=> !armed_q);
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          te_i,
  input  logic          tdre_i,
  input  logic          wr_tdr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          tx_start_o,
  output logic [DW-1:0] tx_data_o
);
  logic [DW-1:0] tdr_q, tdr_n;
  logic          fresh_q, fresh_n;
  logic          start_q, start_n;
  logic          pend;

  assign pend = te_i & ~tdre_i & fresh_q & ~start_q;

  always_comb begin
    tdr_n   = wr_tdr_i ? wdata_i : tdr_q;
    start_n = pend;
    fresh_n = fresh_q;
    if (pend)     fresh_n = 1'b0;
    if (wr_tdr_i) fresh_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_q   <= '0;
      fresh_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (wr_tdr_i) tdr_q <= tdr_n;
      fresh_q <= fresh_n;
      start_q <= start_n;
    end
  end

  assign tx_start_o = start_q;
  assign tx_data_o  = tdr_q;

  // R7: start strobe is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic          rdrf_i,
  input  logic          rx_done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_err_i,
  input  logic          rx_fe_i,
  input  logic          rx_pe_i,
  output logic          set_rdrf_o,
  output logic          set_orer_o,
  output logic          set_fer_o,
  output logic          set_per_o,
  output logic [DW-1:0] rdr_o
);
  logic [DW-1:0] rdr_q;
  logic          take;

  assign take       = re_i & rx_done_i & ~rdrf_i;
  assign set_rdrf_o = take;
  assign set_orer_o = re_i & rx_done_i & rdrf_i;
  assign set_fer_o  = re_i & rx_err_i & rx_fe_i;
  assign set_per_o  = re_i & rx_err_i & rx_pe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdr_q <= '0;
    else if (take) rdr_q <= rx_data_i;
  end

  assign rdr_o = rdr_q;

  // R12: a byte arriving on a full buffer never overwrites it
  a_r12_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rdrf_i) |=> $stable(rdr_q));
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_cs_i,
  input  logic             bus_we_i,
  input  logic [SP_AW-1:0] bus_addr_i,
  input  logic [SP_DW-1:0] bus_wdata_i,
  output logic [SP_DW-1:0] bus_rdata_o,
  output logic             tx_start_o,
  output logic [SP_DW-1:0] tx_data_o,
  input  logic             tx_loaded_i,
  output logic             rx_en_o,
  input  logic             rx_done_i,
  input  logic [SP_DW-1:0] rx_data_i,
  input  logic             rx_err_i,
  input  logic             rx_fe_i,
  input  logic             rx_pe_i,
  output logic             irq_tx_o,
  output logic             irq_rx_o,
  output logic             irq_err_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sp_strobe_t          stb;
  logic [SP_NCTRL-1:0] ctrl_q, ctrl_n;
  logic [SP_NFLAG-1:0] flag_q, flag_set, flag_force;
  logic [SP_DW-1:0]    tdr, rdr;
  logic                set_rdrf, set_orer, set_fer, set_per;
  logic                te, re;

  sport_bus_dec u_dec (
    .bus_cs_i   (bus_cs_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .ctrl_i     (ctrl_q),
    .flag_i     (flag_q),
    .tdr_i      (tdr),
    .rdr_i      (rdr),
    .stb_o      (stb),
    .rdata_o    (bus_rdata_o)
  );

  // control register
  always_comb begin
    ctrl_n = ctrl_q;
    if (stb.wr_ctrl) ctrl_n = bus_wdata_i[SP_CTRL_LSB +: SP_NCTRL];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)           ctrl_q <= '0;
    else if (stb.wr_ctrl) ctrl_q <= ctrl_n;
  end

  assign te = ctrl_q[CI_TE];
  assign re = ctrl_q[CI_RE];

  // flag set and force sources
  always_comb begin
    flag_set          = '0;
    flag_set[FI_TDRE] = tx_loaded_i;
    flag_set[FI_RDRF] = set_rdrf;
    flag_set[FI_ORER] = set_orer;
    flag_set[FI_FER]  = set_fer;
    flag_set[FI_PER]  = set_per;
    flag_force          = '0;
    flag_force[FI_TDRE] = ~te;
  end

  for (genvar gi = 0; gi < SP_NFLAG; gi++) begin : g_flag
    sport_flag #(.RST_VAL(gi == FI_TDRE)) u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .rd_stat_i (stb.rd_stat),
      .wr_stat_i (stb.wr_stat),
      .wbit_i    (bus_wdata_i[SP_FLAG_LSB + gi]),
      .set_i     (flag_set[gi]),
      .force_i   (flag_force[gi]),
      .q_o       (flag_q[gi])
    );
  end

  sport_tx #(.DW(SP_DW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .te_i       (te),
    .tdre_i     (flag_q[FI_TDRE]),
    .wr_tdr_i   (stb.wr_tdr),
    .wdata_i    (bus_wdata_i),
    .tx_start_o (tx_start_o),
    .tx_data_o  (tdr)
  );
  assign tx_data_o = tdr;

  sport_rx #(.DW(SP_DW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .re_i       (re),
    .rdrf_i     (flag_q[FI_RDRF]),
    .rx_done_i  (rx_done_i),
    .rx_data_i  (rx_data_i),
    .rx_err_i   (rx_err_i),
    .rx_fe_i    (rx_fe_i),
    .rx_pe_i    (rx_pe_i),
    .set_rdrf_o (set_rdrf),
    .set_orer_o (set_orer),
    .set_fer_o  (set_fer),
    .set_per_o  (set_per),
    .rdr_o      (rdr)
  );

  assign rx_en_o   = re;
  assign irq_tx_o  = ctrl_q[CI_TIE] & flag_q[FI_TDRE];
  assign irq_rx_o  = ctrl_q[CI_RIE] & flag_q[FI_RDRF];
  assign irq_err_o = ctrl_q[CI_RIE] & (flag_q[FI_ORER] | flag_q[FI_FER] | flag_q[FI_PER]);

  // R9: transmitter off pins the empty flag high
  a_r9_te_off_empty: assert property (@(posedge clk_i) disable iff (!rst_n)
    !te |=> flag_q[FI_TDRE]);
  // R11: receive full cannot rise while the receiver is off
  a_r11_off_no_fill: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!re && !flag_q[FI_RDRF]) |=> !flag_q[FI_RDRF]);
endmodule

// File: tb/sport_ctrl_tb.sv
module sport_ctrl_tb;
  logic       clk, rst_n;
  logic       cs, we;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       tx_start, tx_loaded, rx_en, rx_done, rx_err, rx_fe, rx_pe;
  logic [7:0] tx_data, rx_data;
  logic       irq_tx, irq_rx, irq_err;
  int         n_tests, n_fail;
  logic       done;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TDR = 2'd2, A_RDR = 2'd3;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_RX = 2'd2, K_LD = 2'd3;
  localparam int NV = 20;
  // {kind, addr, data, expected, requirement number}
  localparam logic [23:0] VECS [0:NV-1] = '{
    {K_RD, A_STAT, 8'h00, 8'h80, 4'd1},  // R1 status reset value
    {K_RD, A_CTRL, 8'h00, 8'h00, 4'd1},  // R1 control reset value
    {K_WR, A_CTRL, 8'hFF, 8'h00, 4'd2},
    {K_RD, A_CTRL, 8'h00, 8'hF0, 4'd2},  // R2 low nibble reads 0
    {K_WR, A_CTRL, 8'h30, 8'h00, 4'd2},
    {K_RX, A_STAT, 8'h5A, 8'h00, 4'd11},
    {K_RD, A_STAT, 8'h00, 8'hC0, 4'd11}, // R11 receive full set
    {K_RD, A_RDR,  8'h00, 8'h5A, 4'd11}, // R11 byte stored
    {K_RX, A_STAT, 8'hA5, 8'h00, 4'd12},
    {K_RD, A_RDR,  8'h00, 8'h5A, 4'd12}, // R12 buffer kept
    {K_RD, A_STAT, 8'h00, 8'hE0, 4'd12}, // R12 overrun set
    {K_WR, A_STAT, 8'h00, 8'h00, 4'd5},
    {K_RD, A_STAT, 8'h00, 8'h00, 4'd5},  // R5 read-then-write-0 clears
    {K_WR, A_STAT, 8'hFF, 8'h00, 4'd5},
    {K_RD, A_STAT, 8'h00, 8'h00, 4'd5},  // R5 writing 1 sets nothing
    {K_LD, A_STAT, 8'h00, 8'h00, 4'd8},
    {K_RD, A_STAT, 8'h00, 8'h80, 4'd8},  // R8 load sets empty
    {K_WR, A_STAT, 8'hFF, 8'h00, 4'd6},  // R5 one has no effect
    {K_WR, A_STAT, 8'h00, 8'h00, 4'd6},
    {K_RD, A_STAT, 8'h00, 8'h80, 4'd6}   // R6 read consumed by first write
  };

  sport_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_cs_i    (cs),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .tx_start_o  (tx_start),
    .tx_data_o   (tx_data),
    .tx_loaded_i (tx_loaded),
    .rx_en_o     (rx_en),
    .rx_done_i   (rx_done),
    .rx_data_i   (rx_data),
    .rx_err_i    (rx_err),
    .rx_fe_i     (rx_fe),
    .rx_pe_i     (rx_pe),
    .irq_tx_o    (irq_tx),
    .irq_rx_o    (irq_rx),
    .irq_err_o   (irq_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    rx_done = 1'b1; rx_data = d;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  task automatic rx_error(input logic fe, input logic pe);
    rx_err = 1'b1; rx_fe = fe; rx_pe = pe;
    @(negedge clk);
    rx_err = 1'b0; rx_fe = 1'b0; rx_pe = 1'b0;
  endtask

  task automatic tx_load();
    tx_loaded = 1'b1;
    @(negedge clk);
    tx_loaded = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    done = 1'b0; n_tests = 0; n_fail = 0;
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    tx_loaded = 1'b0; rx_done = 1'b0; rx_data = '0; rx_err = 1'b0; rx_fe = 1'b0; rx_pe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 output levels after reset
    check("R1 irq lines", {5'd0, irq_tx, irq_rx, irq_err}, 8'h00);
    check("R1 tx_start/rx_en", {6'd0, tx_start, rx_en}, 8'h00);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i][23:22])
        K_WR: bus_wr(VECS[i][21:20], VECS[i][19:12]);
        K_RX: rx_byte(VECS[i][19:12]);
        K_LD: tx_load();
        default: begin
          bus_rd(VECS[i][21:20], d);
          check($sformatf("R%0d vector %0d", VECS[i][3:0], i), d, VECS[i][11:4]);
        end
      endcase
    end

    // R3: transmit interrupt follows enable and empty flag
    bus_wr(A_CTRL, 8'hB0);
    check("R3 irq_tx on", {7'd0, irq_tx}, 8'h01);
    bus_wr(A_CTRL, 8'h30);
    check("R3 irq_tx cancelled by enable", {7'd0, irq_tx}, 8'h00);

    // R7: start strobe after data write plus empty cleared
    bus_wr(A_TDR, 8'h3C);
    bus_rd(A_STAT, d);
    check("R7 empty before clear", d, 8'h80);
    bus_wr(A_STAT, 8'h7F);
    #1 check("R7 no strobe yet", {7'd0, tx_start}, 8'h00);
    @(negedge clk);
    #1 check("R7 strobe", {7'd0, tx_start}, 8'h01);
    check("R7 tx data", tx_data, 8'h3C);
    @(negedge clk);
    #1 check("R7 strobe ends", {7'd0, tx_start}, 8'h00);
    repeat (3) @(negedge clk);
    check("R7 single strobe", {7'd0, tx_start}, 8'h00);
    bus_rd(A_STAT, d);
    check("R7 empty cleared", d, 8'h00);
    tx_load();
    bus_rd(A_STAT, d);
    check("R8 empty set by load", d, 8'h80);

    // R13, R4: error flags and interrupts
    bus_wr(A_CTRL, 8'h70);
    rx_error(1'b1, 1'b0);
    bus_rd(A_STAT, d);
    check("R13 framing flag", d, 8'h90);
    check("R4 irq_err on", {7'd0, irq_err}, 8'h01);
    rx_error(1'b0, 1'b1);
    bus_rd(A_STAT, d);
    check("R13 parity flag", d, 8'h98);
    bus_wr(A_STAT, 8'hE7);
    bus_rd(A_STAT, d);
    check("R5 selective clear", d, 8'h80);
    check("R4 irq_err cancelled by flag clear", {7'd0, irq_err}, 8'h00);
    rx_byte(8'h11);
    check("R4 irq_rx on", {7'd0, irq_rx}, 8'h01);
    bus_wr(A_CTRL, 8'h30);
    check("R4 irq_rx cancelled by enable", {7'd0, irq_rx}, 8'h00);

    // R10: receiver off keeps flags and buffer
    bus_wr(A_CTRL, 8'h20);
    check("R10 rx_en low", {7'd0, rx_en}, 8'h00);
    bus_rd(A_STAT, d);
    check("R10 flags kept", d, 8'hC0);
    bus_rd(A_RDR, d);
    check("R10 buffer kept", d, 8'h11);

    // R11: events ignored while receiver off
    rx_byte(8'h77);
    rx_error(1'b1, 1'b1);
    bus_rd(A_STAT, d);
    check("R11 events ignored flags", d, 8'hC0);
    bus_rd(A_RDR, d);
    check("R11 events ignored buffer", d, 8'h11);

    // R9: transmitter off pins empty flag
    bus_wr(A_CTRL, 8'h00);
    bus_rd(A_STAT, d);
    bus_wr(A_STAT, 8'h00);
    bus_rd(A_STAT, d);
    check("R9 empty held with transmitter off", d, 8'h80);
    bus_wr(A_CTRL, 8'h80);
    check("R3 irq_tx with forced empty", {7'd0, irq_tx}, 8'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule